// File: doc/BRIEF.md
# Integrity-Check Sequencer with Violation Reporting

This block holds the command, control and status logic that sits in front of a memory hashing engine. Software drives it through three registers. A command register accepts strobes: a single hash pass, entry into continuous run-time checking, a stop request and a software reset. A control register holds the run-time enable. A status register reports busy, completion, error, rejected-command and mode flags. The block starts the engine with a one-cycle pulse and collects its done and error result.

A hash error found during continuous checking sets the error flag and raises a sticky security-violation output. An error found during a single pass only sets the error flag, whatever the value of the enable bit. The mode the block is actually running in decides whether a violation is raised; the enable bit alone never does. Only a write of one to the reset bit resets the block. Reads have no side effect on any register. When a software reset is written while an engine pass is still outstanding, the block waits for that pass to finish and throws away its result.

Register map: command at word address 0, control at 1, status at 2. Read data appears one cycle after the read strobe.

Top module: `intchk_ctrl`

## Requirements
- R1: After hardware reset (rstN low), status reads 0, control reads 0, engStart is 0 and secViol is 0.
- R2: Writing command bit 0 (single pass) while idle pulses engStart for exactly one cycle, starting the cycle after the write, and sets status bit 0 (busy) until engDone. It then clears busy and sets status bit 1 (pass done). If command bits 0 and 2 are written together while idle, only the single pass starts.
- R3: An engDone with engErr during a single pass sets status bit 2 (error) and leaves secViol at 0, even when control bit 0 (run-time enable) is 1.
- R4: Writing command bit 2 (run start) while idle with control bit 0 set enters run-time mode (status bits 4 and 0 set) and pulses engStart. Every engDone without error pulses engStart again in the following cycle.
- R5: An engDone with engErr in run-time mode sets status bit 2, raises secViol and status bit 5, and leaves run-time mode. This holds even if control bit 0 was cleared after the mode was entered.
- R6: A run start written while control bit 0 is 0 is ignored: no engStart, and the status is unchanged.
- R7: Command bit 3 (stop) in run-time mode ends the mode at the next clean engDone, with no further engStart, and busy clears.
- R8: A single-pass or run-start command written while busy is ignored and sets status bit 3 (rejected).
- R9: Command bit 1 (software reset) clears the error, rejected, pass-done and run-time flags. secViol and status bit 5 stay set until hardware reset.
- R10: A software reset written while an engine pass is outstanding keeps busy set until that pass's engDone. That engDone is discarded: no error flag is set, even if engErr is high.
- R11: Reading any register, the command register included, changes no state. The command register reads as 0.
- R12: When the reset bit is written together with other command bits, the reset wins and the other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register word address |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid the cycle after regRdEn |
| engStart | output | 1 | One-cycle start pulse to the hash engine |
| engDone | input | 1 | Engine pass finished (one-cycle pulse) |
| engErr | input | 1 | Hash mismatch, qualified by engDone |
| secViol | output | 1 | Sticky security violation |

## Verification
Assertions check on every cycle the following: a violation only ever rises after an erroring engine completion seen in run-time mode; the violation never falls outside hardware reset; the error flag only rises on an engine error; rejections only happen while busy; start pulses last one cycle and only while busy; and a bare read leaves busy, mode, error and reject state unchanged. Only the bench's scenarios can show the command sequences themselves. These include priority between bits written in the same word, stopping at the next pass boundary, the drain after a mid-pass software reset, and the violation still being raised after the enable bit is cleared.

// File: rtl/intchk_pkg.sv
package intchk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ONCE  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DRAIN = 2'd3
  } ctrlState_t;

  // command bit positions (software visible)
  localparam int CMD_ONCE_BIT = 0;
  localparam int CMD_RST_BIT  = 1;
  localparam int CMD_RUN_BIT  = 2;
  localparam int CMD_STOP_BIT = 3;

  // control bit positions
  localparam int CTL_RTEN_BIT = 0;

  // status bit positions
  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_DONE_BIT  = 1;
  localparam int ST_ERR_BIT   = 2;
  localparam int ST_REJ_BIT   = 3;
  localparam int ST_RUN_BIT   = 4;
  localparam int ST_VIOL_BIT  = 5;
  localparam int STAT_W       = 6;

  typedef struct packed {
    logic hashOnce;
    logic swReset;
    logic runStart;
    logic runStop;
  } cmdReq_t;

  typedef struct packed {
    logic setErr;
    logic setViol;
    logic setOnceDone;
    logic clrOnceDone;
    logic setReject;
    logic clrStatus;
  } statStrobe_t;

endpackage

// File: rtl/intchk_ctrl_fsm.sv
module intchk_ctrl_fsm
  import intchk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  cmdReq_t     cmdReq,
  input  logic        rtEnable,
  input  logic        engDone,
  input  logic        engErr,
  output logic        engStart,
  output statStrobe_t strobe,
  output logic        busy,
  output logic        runMode
);

  ctrlState_t state, nextState;
  logic stopPending, stopNext;
  logic startNext;
  logic newWork;

  always_comb begin
    nextState = state;
    stopNext  = stopPending;
    startNext = 1'b0;
    strobe    = '0;
    newWork   = cmdReq.hashOnce | cmdReq.runStart;
    if (cmdReq.swReset) begin
      // reset dominates every other bit of the same write
      strobe.clrStatus = 1'b1;
      stopNext         = 1'b0;
      nextState        = (state != ST_IDLE && !engDone) ? ST_DRAIN : ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmdReq.hashOnce) begin
            nextState          = ST_ONCE;
            startNext          = 1'b1;
            strobe.clrOnceDone = 1'b1;
          end else if (cmdReq.runStart && rtEnable) begin
            nextState          = ST_RUN;
            startNext          = 1'b1;
            strobe.clrOnceDone = 1'b1;
          end
        end
        ST_ONCE: begin
          strobe.setReject = newWork;
          if (engDone) begin
            nextState          = ST_IDLE;
            strobe.setOnceDone = 1'b1;
            strobe.setErr      = engErr;
          end
        end
        ST_RUN: begin
          strobe.setReject = newWork;
          if (cmdReq.runStop) stopNext = 1'b1;
          if (engDone) begin
            if (engErr) begin
              strobe.setErr  = 1'b1;
              strobe.setViol = 1'b1;
              nextState      = ST_IDLE;
              stopNext       = 1'b0;
            end else if (stopPending || cmdReq.runStop) begin
              nextState = ST_IDLE;
              stopNext  = 1'b0;
            end else begin
              startNext = 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          strobe.setReject = newWork;
          if (engDone) nextState = ST_IDLE;
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      stopPending <= 1'b0;
      engStart    <= 1'b0;
    end else begin
      state       <= nextState;
      stopPending <= stopNext;
      engStart    <= startNext;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign runMode = (state == ST_RUN);

endmodule

// File: rtl/intchk_ctrl_regs.sv
module intchk_ctrl_regs
  import intchk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CMD_ADDR  = 0,
  parameter int CTL_ADDR  = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  statStrobe_t       strobe,
  input  logic              busy,
  input  logic              runMode,
  output cmdReq_t           cmdReq,
  output logic              rtEnable,
  output logic              errFlag,
  output logic              rejFlag,
  output logic              secViol
);

  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(CMD_ADDR);
  localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic cmdWrite, ctlWrite;
  logic onceDone;
  logic [STAT_W-1:0] statVec;
  logic [DATA_W-1:0] rdNext;

  assign cmdWrite = regWrEn && (regAddr == CMD_A);
  assign ctlWrite = regWrEn && (regAddr == CTL_A);

  // command strobes exist only for the cycle of the write
  always_comb begin
    cmdReq.hashOnce = cmdWrite && regWrData[CMD_ONCE_BIT];
    cmdReq.swReset  = cmdWrite && regWrData[CMD_RST_BIT];
    cmdReq.runStart = cmdWrite && regWrData[CMD_RUN_BIT];
    cmdReq.runStop  = cmdWrite && regWrData[CMD_STOP_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rtEnable <= 1'b0;
    else if (ctlWrite) rtEnable <= regWrData[CTL_RTEN_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      rejFlag  <= 1'b0;
      onceDone <= 1'b0;
    end else if (strobe.clrStatus) begin
      errFlag  <= 1'b0;
      rejFlag  <= 1'b0;
      onceDone <= 1'b0;
    end else begin
      if (strobe.setErr)    errFlag <= 1'b1;
      if (strobe.setReject) rejFlag <= 1'b1;
      if (strobe.setOnceDone)      onceDone <= 1'b1;
      else if (strobe.clrOnceDone) onceDone <= 1'b0;
    end
  end

  // violation survives software reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) secViol <= 1'b0;
    else if (strobe.setViol) secViol <= 1'b1;
  end

  always_comb begin
    statVec              = '0;
    statVec[ST_BUSY_BIT] = busy;
    statVec[ST_DONE_BIT] = onceDone;
    statVec[ST_ERR_BIT]  = errFlag;
    statVec[ST_REJ_BIT]  = rejFlag;
    statVec[ST_RUN_BIT]  = runMode;
    statVec[ST_VIOL_BIT] = secViol;
  end

  always_comb begin
    rdNext = '0;
    if (regAddr == STAT_A)     rdNext[STAT_W-1:0]   = statVec;
    else if (regAddr == CTL_A) rdNext[CTL_RTEN_BIT] = rtEnable;
    // command register always reads as zero
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else if (regRdEn) regRdData <= rdNext;
  end

endmodule

// File: rtl/intchk_ctrl.sv
module intchk_ctrl
  import intchk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CMD_ADDR  = 0,
  parameter int CTL_ADDR  = 1,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              engStart,
  input  logic              engDone,
  input  logic              engErr,
  output logic              secViol
);

  cmdReq_t     cmdReq;
  statStrobe_t strobe;
  logic        rtEnable;
  logic        busyW;
  logic        runModeW;
  logic        errW;
  logic        rejW;

  intchk_ctrl_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .cmdReq   (cmdReq),
    .rtEnable (rtEnable),
    .engDone  (engDone),
    .engErr   (engErr),
    .engStart (engStart),
    .strobe   (strobe),
    .busy     (busyW),
    .runMode  (runModeW)
  );

  intchk_ctrl_regs #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CMD_ADDR  (CMD_ADDR),
    .CTL_ADDR  (CTL_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .busy      (busyW),
    .runMode   (runModeW),
    .cmdReq    (cmdReq),
    .rtEnable  (rtEnable),
    .errFlag   (errW),
    .rejFlag   (rejW),
    .secViol   (secViol)
  );

endmodule

// File: rtl/intchk_ctrl_chk.sv
module intchk_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic regRdEn,
  input logic engStart,
  input logic engDone,
  input logic engErr,
  input logic secViol,
  input logic busyW,
  input logic runModeW,
  input logic errW,
  input logic rejW
);

  // R5: violation only follows an erroring completion in run-time mode
  a_r5_viol_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(secViol) |-> $past(runModeW && engDone && engErr));

  // R9: violation is sticky
  a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rstN)
    secViol |=> secViol);

  // R3: error flag only rises on an engine error
  a_r3_err_from_engine: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errW) |-> $past(engDone && engErr));

  // R8: rejection only for a write seen while busy
  a_r8_reject_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rejW) |-> $past(busyW && regWrEn));

  // R2: start is a single-cycle pulse
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  // R4: start only while a pass is owned
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busyW);

  // R11: a bare read leaves control state alone
  a_r11_read_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && !regWrEn && !engDone) |=>
      ($stable(busyW) && $stable(runModeW) && $stable(errW) && $stable(rejW)));

endmodule

bind intchk_ctrl intchk_ctrl_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .engStart (engStart),
  .engDone  (engDone),
  .engErr   (engErr),
  .secViol  (secViol),
  .busyW    (busyW),
  .runModeW (runModeW),
  .errW     (errW),
  .rejW     (rejW)
);

// File: tb/intchk_ctrl_tb.sv
module intchk_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTL  = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  localparam logic [1:0] OP_WCMD = 2'd0;
  localparam logic [1:0] OP_WCTL = 2'd1;
  localparam logic [1:0] OP_OK   = 2'd2;
  localparam logic [1:0] OP_ERR  = 2'd3;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] data;
    logic [5:0] expSt;
    logic       expStart;
    logic       expViol;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{OP_WCTL, 8'h01, 6'h00, 1'b0, 1'b0, 4'd3},   // R3 setup: enable on
    '{OP_WCMD, 8'h01, 6'h01, 1'b1, 1'b0, 4'd2},   // R2 single pass
    '{OP_WCMD, 8'h01, 6'h09, 1'b0, 1'b0, 4'd8},   // R8 reject while busy
    '{OP_ERR,  8'h00, 6'h0E, 1'b0, 1'b0, 4'd3},   // R3 error, no violation
    '{OP_WCMD, 8'h02, 6'h00, 1'b0, 1'b0, 4'd9},   // R9 soft reset clears
    '{OP_WCMD, 8'h04, 6'h11, 1'b1, 1'b0, 4'd4},   // R4 run start
    '{OP_OK,   8'h00, 6'h11, 1'b1, 1'b0, 4'd4},   // R4 restart after clean pass
    '{OP_WCTL, 8'h00, 6'h11, 1'b0, 1'b0, 4'd5},   // R5 clear enable mid-run
    '{OP_ERR,  8'h00, 6'h24, 1'b0, 1'b1, 4'd5},   // R5 violation by mode
    '{OP_WCMD, 8'h02, 6'h20, 1'b0, 1'b1, 4'd9},   // R9 violation sticky
    '{OP_WCMD, 8'h04, 6'h20, 1'b0, 1'b1, 4'd6},   // R6 run start ignored
    '{OP_WCTL, 8'h01, 6'h20, 1'b0, 1'b1, 4'd7},   // R7 setup
    '{OP_WCMD, 8'h04, 6'h31, 1'b1, 1'b1, 4'd7},   // R7 run
    '{OP_WCMD, 8'h08, 6'h31, 1'b0, 1'b1, 4'd7},   // R7 stop pending
    '{OP_OK,   8'h00, 6'h20, 1'b0, 1'b1, 4'd7},   // R7 stops at boundary
    '{OP_WCMD, 8'h01, 6'h21, 1'b1, 1'b1, 4'd10},  // R10 setup pass
    '{OP_WCMD, 8'h02, 6'h21, 1'b0, 1'b1, 4'd10},  // R10 drain keeps busy
    '{OP_WCMD, 8'h01, 6'h29, 1'b0, 1'b1, 4'd8},   // R8 reject during drain
    '{OP_ERR,  8'h00, 6'h28, 1'b0, 1'b1, 4'd10},  // R10 discarded error
    '{OP_WCMD, 8'h02, 6'h20, 1'b0, 1'b1, 4'd9},   // R9 clear reject
    '{OP_WCMD, 8'h03, 6'h20, 1'b0, 1'b1, 4'd12},  // R12 reset wins
    '{OP_WCMD, 8'h05, 6'h21, 1'b1, 1'b1, 4'd2},   // R2 single pass over run start
    '{OP_OK,   8'h00, 6'h22, 1'b0, 1'b1, 4'd2}    // R2 pass done
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic engStart;
  logic engDone = 1'b0;
  logic engErr = 1'b0;
  logic secViol;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  intchk_ctrl dut_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .engStart  (engStart),
    .engDone   (engDone),
    .engErr    (engErr),
    .secViol   (secViol)
  );

  task automatic check(input string req, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rdReg(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic engFinish(input logic e);
    engDone = 1'b1; engErr = e;
    @(negedge clk);
    engDone = 1'b0; engErr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 engStart", {31'b0, engStart}, 32'd0);
    check("R1 secViol", {31'b0, secViol}, 32'd0);
    rdReg(A_STAT, rd); check("R1 status", rd, 32'h0);
    rdReg(A_CTL, rd);  check("R1 control", rd, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      case (VECS[i].op)
        OP_WCMD: wrReg(A_CMD, {24'b0, VECS[i].data});
        OP_WCTL: wrReg(A_CTL, {24'b0, VECS[i].data});
        OP_OK:   engFinish(1'b0);
        default: engFinish(1'b1);
      endcase
      check({tag, " start"}, {31'b0, engStart}, {31'b0, VECS[i].expStart});
      check({tag, " viol"}, {31'b0, secViol}, {31'b0, VECS[i].expViol});
      rdReg(A_STAT, rd);
      check({tag, " status"}, rd, {26'b0, VECS[i].expSt});
    end

    // R2 pulse width and R11 command reads
    wrReg(A_CMD, 32'h1);
    check("R2 start high", {31'b0, engStart}, 32'd1);
    @(negedge clk);
    check("R2 start one cycle", {31'b0, engStart}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      rdReg(A_CMD, rd); check("R11 cmd reads zero", rd, 32'h0);
    end
    rdReg(A_STAT, rd); check("R11 busy kept", rd, 32'h21);
    engFinish(1'b1);
    rdReg(A_CMD, rd);  check("R11 cmd zero", rd, 32'h0);
    rdReg(A_STAT, rd); check("R11 error kept after read", rd, 32'h26);
    rdReg(A_CTL, rd);  check("R11 control kept", rd, 32'h1);

    // R1 hardware reset clears the sticky violation
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 viol cleared", {31'b0, secViol}, 32'd0);
    rdReg(A_STAT, rd); check("R1 status after reset", rd, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule